// File: doc/BRIEF.md
# Sign-Magnitude Successive-Approximation Sequencer

This block is the digital controller of a successive-approximation converter that gives a sign-magnitude result. A conversion is requested by a one-cycle start strobe, or by a rising edge on the sample/hold input, in either case while chip select is low. The sequencer first makes one comparison against ground to find the polarity of the held input. It then runs a binary search over a 12-bit magnitude, one bit per clock, from the most significant bit down. It drives each trial code to an external DAC and reads back a one-bit comparator decision.

When the last bit is decided, the sign and magnitude are stored in an output register. The active-low interrupt is pulled low and the end-of-conversion flag is raised. A read strobe with chip select low releases the interrupt. The analog sampling, the DAC and the comparator are outside this block.

The controller has four states. IDLE waits for a request. SIGN makes the ground comparison. TRIAL resolves one magnitude bit per cycle. LATCH stores the result. Its transitions are: IDLE to SIGN on an accepted request, SIGN to TRIAL always, TRIAL to TRIAL while bits remain, TRIAL to LATCH on the last bit, and LATCH to IDLE always.

Top module: `sar_signmag_seq`

## Requirements
- R1: After reset, `busy` is 0, `eoc` is 0, `int_n` is 1 and `result` is 0.
- R2: A `start` strobe sampled high with `cs_n` low while idle begins a conversion, so `busy` is 1 after that edge. A `start` with `cs_n` high is ignored.
- R3: A rising edge of `sh` begins a conversion when `cs_n` is low while idle. A rising edge is `sh` sampled 1 at an edge after being sampled 0 at the previous edge.
- R4: In the cycle after a conversion is accepted, `dac_ref_gnd` is 1 and `dac_code` is 0. The sign is taken from `cmp_hi` in that cycle: 0 when `cmp_hi` is 1 (input above ground) and 1 otherwise.
- R5: The first magnitude trial code is 0x800, with only the MSB set. Each later trial keeps every earlier decided bit and sets the next lower bit to 1.
- R6: A trial bit stays 1 only if `cmp_hi` is 1 for that trial, so the magnitude is the largest code strictly below the input magnitude (0 for an input of 0, saturating at 4095). `result[12]` is the sign and `result[11:0]` is the magnitude.
- R7: Exactly 14 clock edges after the accepting edge, `result` holds the new value, `eoc` is 1 and `int_n` is 0.
- R8: At the accepting edge, `eoc` goes to 0 and `int_n` goes to 1.
- R9: A `rd_req` strobe with `cs_n` low while idle sets `int_n` to 1 at the next edge and leaves `result` unchanged. With `cs_n` high, the strobe has no effect.
- R10: A `start` strobe or an `sh` rising edge during a conversion is ignored. The running conversion ends on its original cycle with its own result.
- R11: `busy` is 1 from the accepting edge until the latching edge, and `eoc` is never 1 while `busy` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select that qualifies start, sh and rd_req |
| start | input | 1 | One-cycle conversion request |
| sh | input | 1 | Sample/hold; a rising edge requests a conversion |
| rd_req | input | 1 | Result-read strobe |
| cmp_hi | input | 1 | Comparator: 1 when the input is above the present reference |
| dac_ref_gnd | output | 1 | Selects ground as the comparator reference (sign cycle) |
| dac_code | output | 12 | Trial magnitude code to the DAC |
| busy | output | 1 | Conversion in progress |
| result | output | 13 | {sign, magnitude} of the last conversion |
| eoc | output | 1 | End of conversion, active high |
| int_n | output | 1 | Result-ready interrupt, active low |

## Verification
A new request and the read of the previous result can arrive in the same cycle. In that case the release of the interrupt and the start of the next conversion both act on `int_n` and `eoc`. The bench pulses `rd_req` and `start` on the same edge just after a result is ready. It then expects `busy` high, `eoc` low and `int_n` high, and the following conversion to finish on time with its own value. A second overlap, a request arriving mid-search, is provoked by pulsing `start` and re-raising `sh` during TRIAL. It is judged by the unchanged completion cycle and result.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SIGN,
        ST_TRIAL,
        ST_LATCH
    } sar_state_e;
endpackage

// File: rtl/sar_rise_detect.sv
module sar_rise_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise
);
    logic level_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level;
    end

    assign rise = level & ~level_q;
endmodule

// File: rtl/sar_approx_reg.sv
module sar_approx_reg #(
    parameter int WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic             cmp_hi,
    output logic [WIDTH-1:0] trial,
    output logic [WIDTH-1:0] acc,
    output logic             last
);
    logic [WIDTH-1:0] ptr;

    // one decided bit and one pointer bit per position; pointer walks down
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic acc_b;
        logic ptr_b;
        logic ptr_in;

        if (i == WIDTH - 1) begin : g_top
            assign ptr_in = 1'b0;
        end else begin : g_low
            assign ptr_in = ptr[i+1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                acc_b <= 1'b0;
                ptr_b <= 1'b0;
            end else if (load) begin
                acc_b <= 1'b0;
                ptr_b <= (i == WIDTH - 1);
            end else if (step) begin
                if (ptr_b && cmp_hi) acc_b <= 1'b1;
                ptr_b <= ptr_in;
            end
        end

        assign acc[i]   = acc_b;
        assign ptr[i]   = ptr_b;
        assign trial[i] = acc_b | ptr_b;
    end

    assign last = ptr[0];
endmodule

// File: rtl/sar_out_latch.sv
module sar_out_latch #(
    parameter int WIDTH = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           begin_conv,
    input  logic           latch_en,
    input  logic           read_ack,
    input  logic           sign_in,
    input  logic [WIDTH-1:0] mag_in,
    output logic [WIDTH:0] result,
    output logic           eoc,
    output logic           int_n
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result <= '0;
            eoc    <= 1'b0;
            int_n  <= 1'b1;
        end else if (begin_conv) begin
            eoc    <= 1'b0;
            int_n  <= 1'b1;
        end else if (latch_en) begin
            result <= {sign_in, mag_in};
            eoc    <= 1'b1;
            int_n  <= 1'b0;
        end else if (read_ack) begin
            int_n  <= 1'b1;
        end
    end
endmodule

// File: rtl/sar_signmag_seq.sv
module sar_signmag_seq #(
    parameter int WIDTH = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             start,
    input  logic             sh,
    input  logic             rd_req,
    input  logic             cmp_hi,
    output logic             dac_ref_gnd,
    output logic [WIDTH-1:0] dac_code,
    output logic             busy,
    output logic [WIDTH:0]   result,
    output logic             eoc,
    output logic             int_n
);
    import sar_seq_pkg::*;

    sar_state_e       state_q, state_d;
    logic             sh_rise;
    logic             accept;
    logic             load, step, latch_en, take_sign;
    logic             sign_q;
    logic [WIDTH-1:0] trial, acc;
    logic             last;

    sar_rise_detect u_sh_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (sh),
        .rise  (sh_rise)
    );

    assign accept = (state_q == ST_IDLE) && !cs_n && (start || sh_rise);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = ST_SIGN;
            ST_SIGN:  state_d = ST_TRIAL;
            ST_TRIAL: if (last) state_d = ST_LATCH;
            ST_LATCH: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs and datapath strobes
    always_comb begin
        busy        = 1'b1;
        dac_ref_gnd = 1'b0;
        dac_code    = '0;
        load        = 1'b0;
        step        = 1'b0;
        latch_en    = 1'b0;
        take_sign   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                busy = 1'b0;
                load = accept;
            end
            ST_SIGN: begin
                dac_ref_gnd = 1'b1;
                take_sign   = 1'b1;
            end
            ST_TRIAL: begin
                dac_code = trial;
                step     = 1'b1;
            end
            ST_LATCH: latch_en = 1'b1;
            default:  busy = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         sign_q <= 1'b0;
        else if (take_sign) sign_q <= ~cmp_hi;
    end

    sar_approx_reg #(.WIDTH(WIDTH)) u_sar (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .step   (step),
        .cmp_hi (cmp_hi),
        .trial  (trial),
        .acc    (acc),
        .last   (last)
    );

    sar_out_latch #(.WIDTH(WIDTH)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .begin_conv (accept),
        .latch_en   (latch_en),
        .read_ack   (!busy && !cs_n && rd_req),
        .sign_in    (sign_q),
        .mag_in     (acc),
        .result     (result),
        .eoc        (eoc),
        .int_n      (int_n)
    );
endmodule

// File: rtl/sar_signmag_chk.sv
module sar_signmag_chk #(
    parameter int WIDTH = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cs_n,
    input logic             start,
    input logic             rd_req,
    input logic             dac_ref_gnd,
    input logic [WIDTH-1:0] dac_code,
    input logic             busy,
    input logic [WIDTH:0]   result,
    input logic             eoc,
    input logic             int_n
);
    localparam logic [WIDTH-1:0] MSB_ONE = {1'b1, {(WIDTH-1){1'b0}}};

    a_r11_busy_no_eoc: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !eoc);

    a_r7_eoc_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eoc) |-> !int_n);

    a_r4_ground_phase: assert property (@(posedge clk) disable iff (!rst_n)
        dac_ref_gnd |-> (busy && dac_code == '0));

    a_r5_first_trial: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(dac_ref_gnd) && busy) |-> dac_code == MSB_ONE);

    a_r10_result_held: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(result));

    a_r9_read_release: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !cs_n && rd_req) |=> int_n);

    a_r2_start_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !cs_n && start) |=> (busy && !eoc && dac_ref_gnd));
endmodule

bind sar_signmag_seq sar_signmag_chk #(.WIDTH(WIDTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_n        (cs_n),
    .start       (start),
    .rd_req      (rd_req),
    .dac_ref_gnd (dac_ref_gnd),
    .dac_code    (dac_code),
    .busy        (busy),
    .result      (result),
    .eoc         (eoc),
    .int_n       (int_n)
);

// File: tb/sim_sar_signmag_seq.sv
`timescale 1ns/1ps
module sim_sar_signmag_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, start = 1'b0, sh = 1'b0, rd_req = 1'b0;
    logic        cmp_hi;
    logic        dac_ref_gnd, busy, eoc, int_n;
    logic [11:0] dac_code;
    logic [12:0] result;
    int          vin = 0;
    int          n_chk = 0, n_bad = 0;
    bit          done = 0;

    always #2.5 clk = ~clk;

    sar_signmag_seq u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .start(start), .sh(sh),
        .rd_req(rd_req), .cmp_hi(cmp_hi), .dac_ref_gnd(dac_ref_gnd),
        .dac_code(dac_code), .busy(busy), .result(result), .eoc(eoc),
        .int_n(int_n)
    );

    // comparator and DAC model, zero latency
    always_comb begin
        if (dac_ref_gnd) cmp_hi = (vin > 0);
        else             cmp_hi = ((vin < 0 ? -vin : vin) > int'(dac_code));
    end

    function automatic logic [12:0] expect_code(int v);
        int a, m;
        a = (v < 0) ? -v : v;
        m = (a == 0) ? 0 : a - 1;
        if (m > 4095) m = 4095;
        return {(v > 0) ? 1'b0 : 1'b1, m[11:0]};
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
        end
    endtask

    // one conversion; use_sh picks the request path, disturb injects requests
    // mid-search, with_rd also pulses a read on the accepting edge
    task automatic convert(int v, bit use_sh, bit disturb, bit with_rd);
        logic [12:0] exp_r;
        vin = v;
        exp_r = expect_code(v);
        @(negedge clk);
        cs_n = 1'b0;
        if (use_sh) sh = 1'b1; else start = 1'b1;
        if (with_rd) rd_req = 1'b1;
        @(negedge clk);
        start = 1'b0; rd_req = 1'b0;
        check(busy == 1'b1, use_sh ? "R3 sh edge accept" : "R2 start accept", busy, 1);
        check(dac_ref_gnd == 1'b1 && dac_code == 12'h000, "R4 ground phase", dac_code, 0);
        check(eoc == 1'b0 && int_n == 1'b1, "R8 flags on start", {eoc, int_n}, 1);
        for (int k = 1; k <= 13; k++) begin
            @(negedge clk);
            if (k == 1) check(dac_code == 12'h800, "R5 first trial", dac_code, 12'h800);
            if (disturb && k == 4) sh = 1'b0;
            if (disturb && k == 5) begin start = 1'b1; sh = 1'b1; end
            if (disturb && k == 6) start = 1'b0;
            check(busy == 1'b1 && eoc == 1'b0, "R11 busy span", {busy, eoc}, 2);
        end
        @(negedge clk);
        check(eoc == 1'b1 && int_n == 1'b0, "R7 completion flags", {eoc, int_n}, 2);
        check(busy == 1'b0, "R11 busy drops", busy, 0);
        check(result == exp_r, disturb ? "R10 result after ignored request" : "R6 result",
              result, exp_r);
        sh = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1471));
        repeat (3) @(negedge clk);
        check(busy == 0 && eoc == 0 && int_n == 1 && result == 0, "R1 reset state",
              {busy, eoc, int_n, result}, 13'h0 | (1 << 13));
        rst_n = 1'b1;
        @(negedge clk);

        // start with chip select high is ignored (R2)
        cs_n = 1'b1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        check(busy == 1'b0, "R2 start ignored without select", busy, 0);

        // directed corners
        convert(0,     0, 0, 0);
        convert(1,     1, 0, 0);
        convert(-1,    0, 0, 0);
        convert(4095,  1, 0, 0);
        convert(4096,  0, 0, 0);
        convert(-4096, 1, 0, 0);
        convert(2048,  0, 0, 0);
        convert(-2049, 0, 1, 0);   // R10 mid-search requests
        convert(1234,  1, 1, 0);   // R10 via sh path

        // read with select high leaves the interrupt low (R9)
        cs_n = 1'b1; rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        @(negedge clk);
        check(int_n == 1'b0, "R9 read ignored without select", int_n, 0);
        cs_n = 1'b0; rd_req = 1'b1;
        @(negedge clk);
        rd_req = 1'b0;
        check(int_n == 1'b1, "R9 read releases interrupt", int_n, 1);
        check(result == expect_code(1234), "R9 read keeps result", result, expect_code(1234));

        // read and new start on the same edge (R8, R9)
        convert(-700, 0, 0, 1);

        // random mix
        for (int i = 0; i < 40; i++) begin
            int v;
            v = int'($urandom_range(8192)) - 4096;
            convert(v, $urandom_range(1), ($urandom_range(7) == 0), ($urandom_range(3) == 0));
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule